// File: doc/BRIEF.md
# Single-Bit Register Operation Unit

This block is the execute stage for a family of single-bit instructions. It takes one 32-bit instruction word together with the current contents of the destination register, the source register and the carry (C) and zero (Z) flags. It picks one bit of the destination word, using the source operand as the bit index. Depending on the two flag-effect bits in the instruction, it does one of two things. It can write a new value into that bit. Or it can fold the bit logically into C and/or Z while leaving the word untouched.

A 4-bit condition field gates every write. A free-running linear feedback shift register provides random bits for the "write random" form. The result appears on the registered outputs one clock after the input is accepted. The surrounding pipeline writes back the destination word when `d_we` is high, C when `c_we` is high and Z when `z_we` is high.

The control is a two-state machine. `ST_IDLE` means no result is held. `ST_ISSUE` means a result is being presented. The transition `ACCEPT` (ST_IDLE to ST_ISSUE) and the transition `STREAM` (ST_ISSUE to ST_ISSUE) are taken when `in_valid` is high. The transition `DRAIN` (ST_ISSUE to ST_IDLE) and the transition `WAIT` (ST_IDLE to ST_IDLE) are taken when it is low.

Top module: `bitop_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. Whenever `out_valid` is low, `d_we`, `c_we` and `z_we` are all low.
- R2: After reset, `out_valid`, `d_we`, `c_we` and `z_we` are low.
- R3: The instruction is split as follows: condition [31:28], opcode [27:21], C effect [20], Z effect [19], immediate flag [18], D field [17:9], S field [8:0]. Only opcodes whose top four bits [27:24] equal 4'b0100 belong to this unit. Any other opcode produces no write of any kind.
- R4: The condition passes when instruction bit 28 + 2*C + Z is 1, evaluated on the incoming C and Z. So 4'hF means always and 4'h0 means never. A failed condition suppresses all writes.
- R5: With both effect bits at 0, opcode bits [23:21] select the new value of the chosen bit: 0 gives 0, 1 gives 1, 2 gives C, 3 gives !C, 4 gives Z, 5 gives !Z, 7 gives the inverse of the bit. `d_we` is then high and no other bit of the word changes.
- R6: Code 6 in write mode loads a pseudo-random bit into the chosen bit and changes no other bit. Over many such operations, both 0 and 1 appear.
- R7: With either effect bit at 1, opcode bits [23:21] select a flag function of the chosen bit b: 0 gives F&b, 1 gives F&!b, 2 gives F|b, 3 gives F|!b, 4 gives F^b, 5 gives F^!b, 6 gives b, 7 gives !b.
- R8: In flag mode, the function is applied to C and to Z independently. C is written, with `c_we` high, only when bit 20 is set. Z is written, with `z_we` high, only when bit 19 is set. A flag that is not written is presented unchanged on its next-value output.
- R9: Flag mode never asserts `d_we` and presents the destination word unchanged. Write mode never asserts `c_we` or `z_we`.
- R10: The bit index is the low 5 bits of the S operand. With bit 18 set the operand is the S field; otherwise it is `s_value`. The upper operand bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| d_value | input | 32 | Current destination register contents |
| s_value | input | 32 | Current source register contents |
| c_in | input | 1 | Current carry flag |
| z_in | input | 1 | Current zero flag |
| out_valid | output | 1 | Result presented this cycle |
| d_result | output | 32 | Destination word after the operation |
| d_we | output | 1 | Destination write enable |
| c_next | output | 1 | Next carry value |
| c_we | output | 1 | Carry write enable |
| z_next | output | 1 | Next zero value |
| z_we | output | 1 | Zero write enable |

## Verification
All eight codes are exercised in both modes, with every effect-bit combination and at all 32 bit positions. Destination words and flags are pseudo-random, so a wrong bit index, a swapped code or a flag crossed with the other flag shows up as a mismatch. The immediate and register forms of the index alternate, and the unused operand always holds a different index with junk in its upper bits; this exposes a wrong source or a too-wide index. A sweep over all 16 condition values against all four flag states confirms the gate. Opcodes outside the group, idle cycles and long runs of random writes confirm the suppression paths and that the random source produces both values.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    localparam int INSTR_W = 32;
    localparam int COND_W  = 4;
    localparam int OPC_W   = 7;
    localparam int FIELD_W = 9;
    localparam int SEL_W   = 3;

    // upper opcode bits that claim an instruction for this unit
    localparam logic [OPC_W-SEL_W-1:0] GROUP_ID = 4'b0100;

    typedef struct packed {
        logic [COND_W-1:0]  cond;
        logic [OPC_W-1:0]   opc;
        logic               eff_c;
        logic               eff_z;
        logic               imm;
        logic [FIELD_W-1:0] dfld;
        logic [FIELD_W-1:0] sfld;
    } instr_t;

    typedef enum logic [SEL_W-1:0] {
        WR_CLR = 3'd0,
        WR_SET = 3'd1,
        WR_C   = 3'd2,
        WR_NC  = 3'd3,
        WR_Z   = 3'd4,
        WR_NZ  = 3'd5,
        WR_RND = 3'd6,
        WR_INV = 3'd7
    } wr_op_e;

    typedef enum logic [1:0] {
        FN_AND  = 2'd0,
        FN_OR   = 2'd1,
        FN_XOR  = 2'd2,
        FN_LOAD = 2'd3
    } flag_fn_e;

    typedef enum logic [1:0] {
        MODE_NONE  = 2'd0,
        MODE_WRITE = 2'd1,
        MODE_FLAG  = 2'd2
    } mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } st_e;

    function automatic logic flag_apply(input flag_fn_e fn, input logic f, input logic b);
        logic r;
        unique case (fn)
            FN_AND:  r = f & b;
            FN_OR:   r = f | b;
            FN_XOR:  r = f ^ b;
            FN_LOAD: r = b;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  instr_t            ins,
    input  logic [WORD_W-1:0] s_value,
    input  logic              c_in,
    input  logic              z_in,
    output mode_e             mode,
    output logic [SEL_W-1:0]  sel,
    output logic              upd_c,
    output logic              upd_z,
    output logic [IDX_W-1:0]  idx
);

    logic group_ok;
    logic cond_ok;
    logic [1:0] flag_pair;

    assign flag_pair = {c_in, z_in};
    assign group_ok  = (ins.opc[OPC_W-1:SEL_W] == GROUP_ID);
    assign cond_ok   = ins.cond[flag_pair];

    // index is taken from the low operand bits only
    assign idx = ins.imm ? ins.sfld[IDX_W-1:0] : s_value[IDX_W-1:0];
    assign sel = ins.opc[SEL_W-1:0];

    always_comb begin
        mode  = MODE_NONE;
        upd_c = 1'b0;
        upd_z = 1'b0;
        if (group_ok && cond_ok) begin
            if (ins.eff_c || ins.eff_z) begin
                mode  = MODE_FLAG;
                upd_c = ins.eff_c;
                upd_z = ins.eff_z;
            end else begin
                mode  = MODE_WRITE;
            end
        end
    end

endmodule

// File: rtl/bitop_lfsr.sv
module bitop_lfsr #(
    parameter int             W    = 32,
    parameter logic [W-1:0]   SEED = 'h1ACE_B00C
) (
    input  logic clk,
    input  logic rst_n,
    output logic rnd_bit
);

    logic [W-1:0] state;
    logic         fb;

    generate
        if (W == 32) begin : g_w32
            assign fb = state[31] ^ state[21] ^ state[1] ^ state[0];
        end else if (W == 16) begin : g_w16
            assign fb = state[15] ^ state[14] ^ state[12] ^ state[3];
        end else begin : g_w8
            assign fb = state[7] ^ state[5] ^ state[4] ^ state[3];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEED;
        else        state <= {state[W-2:0], fb};
    end

    assign rnd_bit = state[0];

    // a zero state would lock the generator at 0
    assert_lfsr_alive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  mode_e             mode,
    input  logic [SEL_W-1:0]  sel,
    input  logic              upd_c,
    input  logic              upd_z,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] d_value,
    input  logic              c_in,
    input  logic              z_in,
    input  logic              rnd,
    output logic [WORD_W-1:0] d_new,
    output logic              d_we,
    output logic              c_new,
    output logic              c_we,
    output logic              z_new,
    output logic              z_we
);

    logic     bit_cur;
    logic     bit_put;
    logic     opnd;
    flag_fn_e fn;

    assign bit_cur = d_value[idx];
    assign opnd    = bit_cur ^ sel[0];
    assign fn      = flag_fn_e'(sel[SEL_W-1:1]);

    always_comb begin
        unique case (wr_op_e'(sel))
            WR_CLR: bit_put = 1'b0;
            WR_SET: bit_put = 1'b1;
            WR_C:   bit_put = c_in;
            WR_NC:  bit_put = ~c_in;
            WR_Z:   bit_put = z_in;
            WR_NZ:  bit_put = ~z_in;
            WR_RND: bit_put = rnd;
            WR_INV: bit_put = ~bit_cur;
        endcase
    end

    always_comb begin
        d_new = d_value;
        d_we  = 1'b0;
        c_new = c_in;
        c_we  = 1'b0;
        z_new = z_in;
        z_we  = 1'b0;
        unique case (mode)
            MODE_WRITE: begin
                d_we       = 1'b1;
                d_new[idx] = bit_put;
            end
            MODE_FLAG: begin
                c_we = upd_c;
                z_we = upd_z;
                if (upd_c) c_new = flag_apply(fn, c_in, opnd);
                if (upd_z) z_new = flag_apply(fn, z_in, opnd);
            end
            default: begin
                d_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int                WORD_W    = 32,
    parameter logic [WORD_W-1:0] LFSR_SEED = 'h1ACE_B00C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [WORD_W-1:0] d_value,
    input  logic [WORD_W-1:0] s_value,
    input  logic              c_in,
    input  logic              z_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] d_result,
    output logic              d_we,
    output logic              c_next,
    output logic              c_we,
    output logic              z_next,
    output logic              z_we
);

    localparam int IDX_W = $clog2(WORD_W);

    instr_t            ins;
    mode_e             mode;
    logic [SEL_W-1:0]  sel;
    logic              upd_c, upd_z;
    logic [IDX_W-1:0]  idx;
    logic              rnd;
    logic [WORD_W-1:0] d_new;
    logic              d_we_c, c_new, c_we_c, z_new, z_we_c;

    st_e               state, state_nx;
    logic [WORD_W-1:0] d_res_q, d_hold_q;
    logic              d_we_q, c_res_q, c_we_q, z_res_q, z_we_q, c_hold_q, z_hold_q;

    assign ins = instr_t'(instr);

    bitop_decode #(.WORD_W(WORD_W)) u_decode (
        .ins     (ins),
        .s_value (s_value),
        .c_in    (c_in),
        .z_in    (z_in),
        .mode    (mode),
        .sel     (sel),
        .upd_c   (upd_c),
        .upd_z   (upd_z),
        .idx     (idx)
    );

    bitop_lfsr #(.W(WORD_W), .SEED(LFSR_SEED)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rnd_bit (rnd)
    );

    bitop_alu #(.WORD_W(WORD_W)) u_alu (
        .mode    (mode),
        .sel     (sel),
        .upd_c   (upd_c),
        .upd_z   (upd_z),
        .idx     (idx),
        .d_value (d_value),
        .c_in    (c_in),
        .z_in    (z_in),
        .rnd     (rnd),
        .d_new   (d_new),
        .d_we    (d_we_c),
        .c_new   (c_new),
        .c_we    (c_we_c),
        .z_new   (z_new),
        .z_we    (z_we_c)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: ACCEPT/STREAM on in_valid, WAIT/DRAIN otherwise
    always_comb begin
        unique case (state)
            ST_IDLE:  state_nx = in_valid ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_nx = in_valid ? ST_ISSUE : ST_IDLE;
        endcase
    end

    // result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_res_q  <= '0;
            d_hold_q <= '0;
            d_we_q   <= 1'b0;
            c_res_q  <= 1'b0;
            c_we_q   <= 1'b0;
            z_res_q  <= 1'b0;
            z_we_q   <= 1'b0;
            c_hold_q <= 1'b0;
            z_hold_q <= 1'b0;
        end else if (in_valid) begin
            d_res_q  <= d_new;
            d_hold_q <= d_value;
            d_we_q   <= d_we_c;
            c_res_q  <= c_new;
            c_we_q   <= c_we_c;
            z_res_q  <= z_new;
            z_we_q   <= z_we_c;
            c_hold_q <= c_in;
            z_hold_q <= z_in;
        end
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        unique case (state)
            ST_IDLE:  out_valid = 1'b0;
            ST_ISSUE: out_valid = 1'b1;
        endcase
        d_result = d_res_q;
        c_next   = c_res_q;
        z_next   = z_res_q;
        d_we     = out_valid & d_we_q;
        c_we     = out_valid & c_we_q;
        z_we     = out_valid & z_we_q;
    end

    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(d_we || c_we || z_we));
    assert_single_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        d_we |-> ($countones(d_result ^ d_hold_q) <= 1));
    assert_mode_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        d_we |-> !(c_we || z_we));
    assert_word_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !d_we) |-> (d_result == d_hold_q));
    assert_c_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !c_we) |-> (c_next == c_hold_q));
    assert_z_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !z_we) |-> (z_next == z_hold_q));

endmodule

// File: tb/bitop_unit_bench.sv
`timescale 1ns/1ps
module bitop_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] d_value = '0;
    logic [31:0] s_value = '0;
    logic        c_in = 1'b0;
    logic        z_in = 1'b0;
    logic        out_valid, d_we, c_next, c_we, z_next, z_we;
    logic [31:0] d_result;

    int checks = 0;
    int errors = 0;
    int rnd_ones = 0;
    int rnd_zeros = 0;
    logic [31:0] seed = 32'h2468_ACE1;

    always #2 clk = ~clk;

    bitop_unit u_bitop_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .d_value(d_value), .s_value(s_value), .c_in(c_in), .z_in(z_in),
        .out_valid(out_valid), .d_result(d_result), .d_we(d_we),
        .c_next(c_next), .c_we(c_we), .z_next(z_next), .z_we(z_we)
    );

    function automatic logic [31:0] nextr(input logic [31:0] x);
        return x * 32'd1664525 + 32'd1013904223;
    endfunction

    function automatic logic [31:0] mk(input logic [3:0] cond, input logic [3:0] grp,
                                       input logic [2:0] op, input logic wc, input logic wz,
                                       input logic imm, input logic [8:0] sf);
        return {cond, grp, op, wc, wz, imm, 9'h1A5, sf};
    endfunction

    // behavioural reference: returns expected values; rnd_pos = -1 unless random write
    task automatic model(input logic [31:0] ins, input logic [31:0] d, input logic [31:0] s,
                         input logic c, input logic z,
                         output logic dwe, output logic cwe, output logic zwe,
                         output logic [31:0] dr, output logic cn, output logic zn,
                         output int rnd_pos);
        int  ix;
        int  op;
        logic b, o;
        dwe = 0; cwe = 0; zwe = 0; dr = d; cn = c; zn = z; rnd_pos = -1;
        ix = ins[18] ? int'(ins[4:0]) : int'(s[4:0]);
        op = int'(ins[23:21]);
        b  = d[ix];
        if (ins[27:24] == 4'b0100 && ins[28 + 2*int'(c) + int'(z)]) begin
            if (!ins[20] && !ins[19]) begin
                dwe = 1;
                case (op)
                    0: dr[ix] = 1'b0;
                    1: dr[ix] = 1'b1;
                    2: dr[ix] = c;
                    3: dr[ix] = !c;
                    4: dr[ix] = z;
                    5: dr[ix] = !z;
                    6: rnd_pos = ix;
                    default: dr[ix] = !b;
                endcase
            end else begin
                o = (op % 2 == 1) ? !b : b;
                cwe = ins[20];
                zwe = ins[19];
                case (op / 2)
                    0: begin if (cwe) cn = c & o; if (zwe) zn = z & o; end
                    1: begin if (cwe) cn = c | o; if (zwe) zn = z | o; end
                    2: begin if (cwe) cn = c ^ o; if (zwe) zn = z ^ o; end
                    default: begin if (cwe) cn = o; if (zwe) zn = o; end
                endcase
            end
        end
    endtask

    // drive at a falling edge, sample at the next falling edge (one register stage)
    task automatic run(input logic [31:0] ins, input logic [31:0] d, input logic [31:0] s,
                       input logic c, input logic z, input string tag);
        logic edwe, ecwe, ezwe, ecn, ezn;
        logic [31:0] edr, mask;
        int rp;
        model(ins, d, s, c, z, edwe, ecwe, ezwe, edr, ecn, ezn, rp);
        in_valid = 1; instr = ins; d_value = d; s_value = s; c_in = c; z_in = z;
        @(negedge clk);
        mask = (rp >= 0) ? ~(32'h1 << rp) : 32'hFFFF_FFFF;
        checks++;
        if (!out_valid || d_we !== edwe || c_we !== ecwe || z_we !== ezwe ||
            c_next !== ecn || z_next !== ezn || ((d_result ^ edr) & mask) != 0) begin
            errors++;
            $display("FAIL %s ins=%h act v=%b dwe=%b cwe=%b zwe=%b c=%b z=%b d=%h exp dwe=%b cwe=%b zwe=%b c=%b z=%b d=%h",
                     tag, ins, out_valid, d_we, c_we, z_we, c_next, z_next, d_result,
                     edwe, ecwe, ezwe, ecn, ezn, edr);
        end
        if (rp >= 0) begin
            if (d_result[rp]) rnd_ones++;
            else rnd_zeros++;
        end
    endtask

    task automatic idle_check(input string tag);
        in_valid = 0;
        @(negedge clk);
        checks++;
        if (out_valid || d_we || c_we || z_we) begin
            errors++;
            $display("FAIL %s act v=%b dwe=%b cwe=%b zwe=%b exp all 0",
                     tag, out_valid, d_we, c_we, z_we);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog act running exp finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [8:0]  sf;
        logic [31:0] sv;
        logic [31:0] d;
        logic        imm;
        string       tag;
        repeat (3) @(negedge clk);
        // R2: reset state
        checks++;
        if (out_valid || d_we || c_we || z_we) begin
            errors++;
            $display("FAIL R2 act v=%b dwe=%b cwe=%b zwe=%b exp all 0", out_valid, d_we, c_we, z_we);
        end
        rst_n = 1;
        @(negedge clk);
        idle_check("R1");

        // all forms x all positions; R5 R6 R7 R8 R9 R10
        for (int eff = 0; eff < 4; eff++) begin
            for (int op = 0; op < 8; op++) begin
                for (int ix = 0; ix < 32; ix++) begin
                    seed = nextr(seed); d = seed;
                    seed = nextr(seed);
                    imm  = ix[0];
                    // the unused operand carries a different index and junk upper bits
                    sf = imm ? {4'b1011, ix[4:0]} : {4'b0110, ix[4:0] ^ 5'h15};
                    sv = imm ? {seed[31:5], ix[4:0] ^ 5'h0B} : {seed[31:5], ix[4:0]};
                    if (eff == 0) tag = (op == 6) ? "R6" : "R5/R9/R10";
                    else          tag = "R7/R8/R9/R10";
                    run(mk(4'hF, 4'b0100, op[2:0], eff[1], eff[0], imm, sf), d, sv,
                        seed[7], seed[13], tag);
                end
            end
        end
        idle_check("R1");

        // R6: long run of random writes
        for (int k = 0; k < 64; k++) begin
            seed = nextr(seed);
            run(mk(4'hF, 4'b0100, 3'd6, 1'b0, 1'b0, 1'b1, {4'h0, seed[4:0]}), seed, 32'h0,
                seed[9], seed[3], "R6");
        end
        checks++;
        if (rnd_ones == 0 || rnd_zeros == 0) begin
            errors++;
            $display("FAIL R6 act ones=%0d zeros=%0d exp both nonzero", rnd_ones, rnd_zeros);
        end

        // R4: condition sweep for both modes
        for (int cnd = 0; cnd < 16; cnd++) begin
            for (int f = 0; f < 4; f++) begin
                seed = nextr(seed);
                run(mk(cnd[3:0], 4'b0100, 3'd7, 1'b0, 1'b0, 1'b1, 9'd9), seed, 32'h0,
                    f[1], f[0], "R4");
                run(mk(cnd[3:0], 4'b0100, 3'd7, 1'b1, 1'b1, 1'b0, 9'd0), seed, 32'd17,
                    f[1], f[0], "R4");
            end
        end

        // R3: opcodes outside the group
        for (int g = 0; g < 16; g++) begin
            if (g != 4) begin
                seed = nextr(seed);
                run(mk(4'hF, g[3:0], seed[2:0], seed[5], seed[6], 1'b1, 9'd3), seed, 32'h0,
                    1'b1, 1'b0, "R3");
            end
        end

        idle_check("R1");
        idle_check("R1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule